// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the bus-facing register set of a small serial peripheral. A word-addressed bus selects one of four 32-bit registers with its byte address shifted right by two. Index 0 holds receive data, index 1 transmit data, index 2 status and index 3 control, so the decoded window is 16 bytes wide. Received bytes arrive on a valid/ready input and are held in an 8-entry FIFO until software reads them. Reading the receive-data register removes the oldest byte from the FIFO.

A write to the transmit register places the low byte on a byte output for one cycle. Transmission is treated as finished at once, so the transmit FIFO always reads as empty. The status register reports FIFO occupancy and an interrupt-pending flag. Once that flag is set, it stays set until reset. The level interrupt output is this flag gated by an enable bit in the control register. Serial framing, baud timing and error detection belong to other blocks. The error bits in status always read as zero.

Top module: `sport_regs`

## Requirements
- R1: A synchronous active-high reset empties the FIFO and clears control, transmit data, pending, read data and the byte strobe. After reset, status reads 0x04, `rx_ready` is 1 and `irq` is 0.
- R2: Bytes accepted while `rx_valid` and `rx_ready` are both high are returned in arrival order by reads of index 0. Each such read removes one byte. A push and a pop in the same cycle are both honoured.
- R3: The FIFO holds 8 bytes. `rx_ready` is 0 exactly when 8 bytes are held. A byte offered while full is dropped, and the stored bytes are unchanged.
- R4: A read of index 0 while the FIFO is empty returns the stale byte at the head slot and leaves the count at zero.
- R5: Status bit0 is 1 when the count is non-zero, and bit1 is 1 when the count is 8. Bit2 is always 1, and bit4 is the pending flag. Bits 3, 5, 6 and 7 and all upper bits read 0.
- R6: A write to index 1 stores the full word, which a read of index 1 returns. The following cycle, `tx_strobe` is 1 for one cycle with `tx_byte` equal to the low 8 bits of the write data.
- R7: The pending flag is set by a write to index 1 and by a non-empty FIFO. It stays set after the FIFO drains and is cleared only by reset.
- R8: `irq` is 1 exactly when the pending flag and control bit4 are both 1.
- R9: A write to index 3 stores the written word, which a read of index 3 returns. If bit1 of the write is set, the FIFO pointer and count are also cleared. A clear takes priority over a push or pop in the same cycle.
- R10: Writes to index 2 and writes outside the 16-byte window change nothing. Reads outside the window return 0.
- R11: Read data appears on `bus_rdata` in the cycle after the one in which `bus_re` is sampled, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Byte address; bits [ADDR_W-1:2] select the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W (32) | Registered read data |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_data | input | BYTE_W (8) | Incoming byte |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_strobe | output | 1 | One-cycle pulse per transmit write |
| tx_byte | output | BYTE_W (8) | Byte written to the transmit register |
| irq | output | 1 | Level interrupt |

## Verification
Every result lands one clock edge after its stimulus:
- read data is due in the cycle after `bus_re`;
- the transmit strobe and byte are due in the cycle after the write;
- status bits, `rx_ready` and `irq` reflect a push, pop, clear or control write right after that same edge.

The bench drives every input on the falling edge and holds it for exactly one rising edge. It samples on the next falling edge, so each check reads the value due after a single register stage. The read-latency scenario also samples just after `bus_re` is raised, to confirm the old value is still held before the edge.

// File: rtl/sport_pkg.sv
package sport_pkg;
  // register indices (byte address >> 2)
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int NUM_REGS   = 4;

  // status bit positions
  localparam int ST_RXVALID = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_PEND    = 4;
  localparam int ST_OVR     = 5;
  localparam int ST_FRM     = 6;
  localparam int ST_PAR     = 7;

  // control bit positions
  localparam int CT_TXRST   = 0;
  localparam int CT_RXRST   = 1;
  localparam int CT_IE      = 4;
endpackage

// File: rtl/sport_rxfifo.sv
module sport_rxfifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push_valid,
  input  logic [BYTE_W-1:0] push_data,
  output logic              push_ready,
  input  logic              pop,
  output logic [BYTE_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  rd_idx;
  logic              do_push, do_pop;
  logic [BYTE_W-1:0] dout_q;

  assign push_ready = (cnt_q != CNT_W'(DEPTH));
  assign do_push    = push_valid && push_ready && !clr;
  assign do_pop     = pop && (cnt_q != '0) && !clr;
  // head slot: write pointer minus occupancy, modulo depth
  assign rd_idx     = wp_q - cnt_q[PTR_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      unique case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wp_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clr)          wp_q <= '0;
      else if (do_push) wp_q <= wp_q + 1'b1;
    end
  end

  // storage array: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      dout_q <= '0;
    else if (pop) dout_q <= mem[rd_idx];
  end

  assign dout      = dout_q;
  assign count     = cnt_q;
  assign count_nxt = cnt_d;
endmodule

// File: rtl/sport_status.sv
module sport_status #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              tx_wr,
  output logic [DATA_W-1:0] status_word,
  output logic              pending
);
  import sport_pkg::*;

  logic pend_q;

  // sticky: set on transmit write or on a non-empty FIFO after this edge
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_q | tx_wr | (cnt_nxt != '0);
  end

  always_comb begin
    status_word             = '0;
    status_word[ST_RXVALID] = (cnt_q != '0);
    status_word[ST_RXFULL]  = (cnt_q == CNT_W'(DEPTH));
    status_word[ST_TXEMPTY] = 1'b1;
    status_word[ST_TXFULL]  = 1'b0;
    status_word[ST_PEND]    = pend_q;
    status_word[ST_OVR]     = 1'b0;
    status_word[ST_FRM]     = 1'b0;
    status_word[ST_PAR]     = 1'b0;
  end

  assign pending = pend_q;
endmodule

// File: rtl/sport_regs.sv
module sport_regs #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  import sport_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = $clog2(RX_DEPTH) + 1;

  logic [IDX_W-1:0]  idx;
  logic              in_win;
  reg_sel_e          sel;
  logic              wr_tx, wr_ctrl, rd_rx, rx_clr;
  logic [DATA_W-1:0] ctrl_q, txd_q, reg_rd_q, status_word;
  logic              rx_sel_q, tx_strobe_q, pend;
  logic [BYTE_W-1:0] tx_byte_q, fifo_dout;
  logic [CNT_W-1:0]  rx_cnt, rx_cnt_nxt;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign in_win  = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
  assign sel     = reg_sel_e'(idx[1:0]);
  assign wr_tx   = bus_we && in_win && (sel == REG_TXD);
  assign wr_ctrl = bus_we && in_win && (sel == REG_CTRL);
  assign rd_rx   = bus_re && in_win && (sel == REG_RXD);
  assign rx_clr  = wr_ctrl && bus_wdata[CT_RXRST];

  sport_rxfifo #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .clr        (rx_clr),
    .push_valid (rx_valid),
    .push_data  (rx_data),
    .push_ready (rx_ready),
    .pop        (rd_rx),
    .dout       (fifo_dout),
    .count      (rx_cnt),
    .count_nxt  (rx_cnt_nxt)
  );

  sport_status #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .cnt_q       (rx_cnt),
    .cnt_nxt     (rx_cnt_nxt),
    .tx_wr       (wr_tx),
    .status_word (status_word),
    .pending     (pend)
  );

  // writable registers and transmit strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      txd_q       <= '0;
      tx_strobe_q <= 1'b0;
      tx_byte_q   <= '0;
    end else begin
      tx_strobe_q <= wr_tx;
      if (wr_tx) begin
        txd_q     <= bus_wdata;
        tx_byte_q <= bus_wdata[BYTE_W-1:0];
      end
      if (wr_ctrl) ctrl_q <= bus_wdata;
    end
  end

  // registered read mux; receive data comes from the FIFO output register
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rx_sel_q <= 1'b0;
    end else if (bus_re) begin
      rx_sel_q <= rd_rx;
      if (!in_win) begin
        reg_rd_q <= '0;
      end else begin
        unique case (sel)
          REG_RXD:  reg_rd_q <= '0;
          REG_TXD:  reg_rd_q <= txd_q;
          REG_STAT: reg_rd_q <= status_word;
          REG_CTRL: reg_rd_q <= ctrl_q;
          default:  reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rx_sel_q ? {{(DATA_W-BYTE_W){1'b0}}, fifo_dout} : reg_rd_q;
  assign tx_strobe = tx_strobe_q;
  assign tx_byte   = tx_byte_q;
  assign irq       = pend & ctrl_q[CT_IE];
endmodule

// File: rtl/sport_regs_chk.sv
module sport_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              pend
);
  // R3
  full_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(DEPTH)) |-> !rx_ready);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));

  // R4
  empty_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !(rx_valid && rx_ready)) |=> (cnt_q == '0));

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pend |=> pend);

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> pend);

  // R6
  strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> $past(bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1))));
endmodule

bind sport_regs sport_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(RX_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_strobe (tx_strobe),
  .irq       (irq),
  .cnt_q     (rx_cnt),
  .pend      (pend)
);

// File: tb/sim_sport_regs.sv
module sim_sport_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] A_RX = 8'h00, A_TX = 8'h04, A_ST = 8'h08, A_CT = 8'h0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  sport_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 tx_strobe", {31'b0, tx_strobe}, 32'h0);
    bus_rd(A_ST, v); chk("R1 R5 status after reset", v, 32'h04);
  endtask

  task automatic t_order();
    logic [31:0] v;
    do_reset();
    push(8'h3C); push(8'hC3); push(8'h5A);
    bus_rd(A_ST, v); chk("R5 status three held", v, 32'h15);
    bus_rd(A_RX, v); chk("R2 first", v, 32'h3C);
    bus_rd(A_RX, v); chk("R2 second", v, 32'hC3);
    bus_rd(A_RX, v); chk("R2 third", v, 32'h5A);
    push(8'h01);
    @(negedge clk);
    bus_addr = A_RX; bus_re = 1'b1; rx_data = 8'h02; rx_valid = 1'b1;
    @(negedge clk);
    bus_re = 1'b0; rx_valid = 1'b0;
    chk("R2 pop with push", bus_rdata, 32'h01);
    bus_rd(A_RX, v); chk("R2 pushed during pop", v, 32'h02);
    bus_rd(A_ST, v); chk("R5 status drained", v, 32'h14);
  endtask

  task automatic t_full_empty();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    chk("R3 ready low when full", {31'b0, rx_ready}, 32'h0);
    bus_rd(A_ST, v); chk("R3 R5 status full", v, 32'h17);
    push(8'hEE);
    for (int i = 0; i < 8; i++) begin
      bus_rd(A_RX, v); chk("R3 contents after drop", v, 32'hA0 + 32'(i));
    end
    bus_rd(A_ST, v); chk("R3 byte offered while full not stored", v, 32'h14);
    bus_rd(A_RX, v); chk("R4 empty read stale", v, 32'hA0);
    bus_rd(A_ST, v); chk("R4 count stays zero", v, 32'h14);
    push(8'h55);
    bus_rd(A_RX, v); chk("R4 no underflow", v, 32'h55);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    do_reset();
    bus_wr(A_TX, 32'hCAFE_12A5);
    chk("R6 strobe high", {31'b0, tx_strobe}, 32'h1);
    chk("R6 tx byte", {24'b0, tx_byte}, 32'hA5);
    @(negedge clk);
    chk("R6 strobe single cycle", {31'b0, tx_strobe}, 32'h0);
    bus_rd(A_TX, v); chk("R6 tx word stored", v, 32'hCAFE_12A5);
    bus_rd(A_ST, v); chk("R7 pending from tx", v, 32'h14);
    chk("R8 irq off while disabled", {31'b0, irq}, 32'h0);
    bus_wr(A_CT, 32'h10);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    bus_wr(A_CT, 32'h00);
    chk("R8 irq off again", {31'b0, irq}, 32'h0);
    bus_rd(A_ST, v); chk("R7 pending sticky", v, 32'h14);
  endtask

  task automatic t_pend_rx();
    logic [31:0] v;
    do_reset();
    push(8'h99);
    bus_rd(A_RX, v); chk("R2 single byte", v, 32'h99);
    bus_rd(A_ST, v); chk("R7 pending stays after drain", v, 32'h14);
  endtask

  task automatic t_ctrl_clear();
    logic [31:0] v;
    do_reset();
    push(8'h11); push(8'h22); push(8'h33);
    bus_wr(A_CT, 32'h12);
    bus_rd(A_ST, v); chk("R9 fifo cleared", v, 32'h14);
    bus_rd(A_CT, v); chk("R9 ctrl stored", v, 32'h12);
    chk("R8 irq with pending", {31'b0, irq}, 32'h1);
    push(8'h77);
    bus_rd(A_RX, v); chk("R9 fresh byte after clear", v, 32'h77);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    do_reset();
    bus_wr(A_CT, 32'h10);
    bus_wr(A_ST, 32'hFFFF_FFFF);
    bus_rd(A_ST, v); chk("R10 status write ignored", v, 32'h04);
    chk("R10 irq unchanged", {31'b0, irq}, 32'h0);
    bus_wr(8'h2C, 32'h0000_0012);
    bus_rd(A_CT, v); chk("R10 out of window write ignored", v, 32'h10);
    bus_rd(8'h24, v); chk("R10 out of window read zero", v, 32'h0);
  endtask

  task automatic t_latency();
    do_reset();
    bus_wr(A_CT, 32'h31);
    @(negedge clk);
    bus_addr = A_CT; bus_re = 1'b1;
    #1 chk("R11 old value before edge", bus_rdata, 32'h0);
    @(negedge clk);
    bus_re = 1'b0;
    chk("R11 data after one edge", bus_rdata, 32'h31);
    repeat (3) @(negedge clk);
    chk("R11 data holds", bus_rdata, 32'h31);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full_empty();
    t_tx();
    t_pend_rx();
    t_ctrl_clear();
    t_ignore();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule